// File: doc/BRIEF.md
# Serial Flash Byte Shift Engine

This block is a single-lane serial master that runs one free-form transaction with a flash device. Software loads up to six outgoing bytes and a bit count through a small register bus, then sets a start bit in the command register. The engine lowers chip select, generates the serial clock from the system clock, shifts the outgoing bytes out most significant bit first, and captures the incoming line into a chain of ten receive byte registers. Software reads those registers once the start bit reads back as zero.

A transaction is at most 56 bits. Any bits past the 48 held in the transmit registers go out as zeros, so opcode, address and dummy bytes can be sent first and a read response can then be clocked in. Received bytes enter the chain at its bottom and push older bytes upward. The most recent complete byte is therefore always at receive index 0.

Top module: `flash_byte_shifter`

## Requirements
- R1: After reset chip select is high, the serial clock is low, and the command register, bit count register and all ten receive registers read 0.
- R2: The register map is: command at address 0, bit count at address 1, transmit bytes 0..5 at addresses 8..13 (readable), receive bytes 0..9 at addresses 16..25 (read only). Any other address reads 0.
- R3: Writing the command register with bit 2 set while idle and with a nonzero bit count starts a transaction. Bit 2 reads 1 until the engine finishes and then reads 0 without any further write. Command bits 0, 1, 3, 4 and 5 are stored and read back, and they start nothing.
- R4: Bits leave MSB first, starting with transmit byte 5, then byte 4, and so on down to byte 0.
- R5: For bit counts above 48, every bit after the 48th is driven as 0.
- R6: The bit count register holds a count of bits. A written value above 56 is stored as 56.
- R7: The clock uses mode 0. It is low whenever chip select is high. MOSI does not change while the clock is high. Each clock phase, the chip-select lead time before the first rising edge, and the hold time after the last falling edge are each HALF_DIV system clocks long.
- R8: A start with a bit count of 0 finishes at once. Chip select never falls, and bit 2 reads 0 on the next read.
- R9: MISO is sampled on rising edges. Every eighth sampled bit completes a byte, which is written to receive index 0 while each older byte moves up one index; the byte at index 9 is lost. Trailing bits that do not complete a byte are not stored.
- R10: While a transaction runs, writes to the transmit registers, the bit count register and the command register are ignored.
- R11: The number of serial clock pulses in a transaction equals the programmed bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 5 | Register address |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Register read data, combinational from busAddr |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A wrong phase counter shows up at the first clock edge of a transaction as a lead time or pulse width that differs from HALF_DIV. A wrong bit counter shows up at chip-select release as a pulse count that differs from the programmed length. Mistakes in load order or shift direction corrupt the captured MOSI word on the first bit. Mistakes in the receive chain or in byte framing show up when the receive registers are read back after each transaction, and the model of ten bytes deep exposes a lost or duplicated push across several transactions.

// File: rtl/flash_shift_pkg.sv
package flash_shift_pkg;

  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic load;    // copy transmit registers into the shifter
    logic sample;  // capture spiMiso (coincides with the rising clock edge)
    logic shift;   // advance spiMosi (coincides with the falling clock edge)
    logic push;    // a byte is complete: enter it into the receive chain
  } shiftStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } engState_t;

endpackage

// File: rtl/fbs_control.sv
module fbs_control
  import flash_shift_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] bitTotal,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output shiftStrobes_t    strb
);

  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  engState_t        state;
  logic [HC_W-1:0]  halfCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic [2:0]       bitIdx;
  logic             halfEnd;
  logic             launch;

  assign halfEnd = (halfCnt == HC_W'(HALF_DIV - 1));
  assign launch  = (state == ST_IDLE) && startReq && (bitTotal != '0);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb        = '0;
    strb.load   = launch;
    strb.sample = (state == ST_LOW) && halfEnd;
    strb.push   = (state == ST_LOW) && halfEnd && (bitIdx == 3'd7);
    strb.shift  = (state == ST_HIGH) && halfEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      halfCnt  <= '0;
      bitsLeft <= '0;
      bitIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state    <= ST_LOW;
            csN      <= 1'b0;
            halfCnt  <= '0;
            bitsLeft <= bitTotal;
            bitIdx   <= '0;
          end
        end
        ST_LOW: begin
          if (halfEnd) begin
            halfCnt <= '0;
            sclk    <= 1'b1;
            bitIdx  <= bitIdx + 1'b1;
            state   <= ST_HIGH;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            halfCnt  <= '0;
            sclk     <= 1'b0;
            bitsLeft <= bitsLeft - 1'b1;
            state    <= (bitsLeft == CNT_W'(1)) ? ST_TAIL : ST_LOW;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: begin
          if (halfEnd) begin
            halfCnt <= '0;
            csN     <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_CS_GATES_CLK: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);  // R7

  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> ($past(state) == ST_LOW));  // R7

  AST_RELEASE_FROM_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ($past(state) == ST_TAIL));  // R7

  AST_ZERO_LEN_NO_CS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && startReq && (bitTotal == '0)) |=> (csN && !busy));  // R8

  AST_HIGH_HAS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH) |-> (bitsLeft != '0));  // R11

endmodule

// File: rtl/fbs_datapath.sv
module fbs_datapath
  import flash_shift_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              busy,
  input  shiftStrobes_t     strb,
  input  logic              miso,
  output logic              mosi,
  output logic              startReq,
  output logic [CNT_W-1:0]  bitTotal
);

  localparam int TX_W     = TX_BYTES * 8;
  localparam int CMD_ADDR = 0;
  localparam int CNT_ADDR = 1;
  localparam int TX_BASE  = 8;
  localparam int RX_BASE  = 16;
  localparam int GO_BIT   = 2;

  logic [7:0]       txReg [TX_BYTES];
  logic [7:0]       rxReg [RX_BYTES];
  logic [TX_W-1:0]  txFlat;
  logic [TX_W-1:0]  shiftReg;
  logic [7:0]       rxAsm;
  logic [CNT_W-1:0] countReg;
  logic [5:0]       cmdKeep;
  logic             wrCmd;
  logic             wrCnt;

  assign wrCmd    = busWrEn && (busAddr == ADDR_W'(CMD_ADDR)) && !busy;
  assign wrCnt    = busWrEn && (busAddr == ADDR_W'(CNT_ADDR)) && !busy;
  assign startReq = wrCmd && busWrData[GO_BIT];
  assign bitTotal = countReg;
  assign mosi     = shiftReg[TX_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdKeep  <= '0;
      countReg <= '0;
    end else begin
      if (wrCmd) cmdKeep <= busWrData[5:0] & ~(6'd1 << GO_BIT);
      if (wrCnt) begin
        if (busWrData > 8'(MAX_BITS)) countReg <= CNT_W'(MAX_BITS);
        else                          countReg <= CNT_W'(busWrData);
      end
    end
  end

  // Transmit byte registers; index TX_BYTES-1 sits at the top of the shifter.
  for (genvar g = 0; g < TX_BYTES; g++) begin : gTx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) txReg[g] <= '0;
      else if (busWrEn && !busy && (busAddr == ADDR_W'(TX_BASE + g)))
        txReg[g] <= busWrData;
    end
    assign txFlat[g*8 +: 8] = txReg[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxAsm    <= '0;
    end else begin
      if (strb.load)       shiftReg <= txFlat;
      else if (strb.shift) shiftReg <= {shiftReg[TX_W-2:0], 1'b0};
      if (strb.sample)     rxAsm    <= {rxAsm[6:0], miso};
    end
  end

  // Receive chain: new bytes enter at index 0, older ones move upward.
  for (genvar g = 0; g < RX_BYTES; g++) begin : gRx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rxReg[g] <= '0;
      else if (strb.push) begin
        if (g == 0) rxReg[g] <= {rxAsm[6:0], miso};
        else        rxReg[g] <= rxReg[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(CMD_ADDR))
      busRdData = {2'b00, cmdKeep[5:3], busy, cmdKeep[1:0]};
    if (busAddr == ADDR_W'(CNT_ADDR))
      busRdData = 8'(countReg);
    for (int i = 0; i < TX_BYTES; i++)
      if (busAddr == ADDR_W'(TX_BASE + i)) busRdData = txReg[i];
    for (int i = 0; i < RX_BYTES; i++)
      if (busAddr == ADDR_W'(RX_BASE + i)) busRdData = rxReg[i];
  end

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (countReg <= CNT_W'(MAX_BITS)));  // R6

  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(txFlat) && $stable(countReg)));  // R10

  AST_PUSH_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> strb.sample);  // R9

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !busy);  // R3

endmodule

// File: rtl/flash_byte_shifter.sv
module flash_byte_shifter
  import flash_shift_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);

  localparam int CNT_W = $clog2(MAX_BITS + 1);

  shiftStrobes_t    strb;
  logic             busy;
  logic             startReq;
  logic [CNT_W-1:0] bitTotal;

  fbs_control #(
    .HALF_DIV (HALF_DIV),
    .CNT_W    (CNT_W)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .bitTotal (bitTotal),
    .csN      (spiCsN),
    .sclk     (spiSclk),
    .busy     (busy),
    .strb     (strb)
  );

  fbs_datapath #(
    .TX_BYTES (TX_BYTES),
    .RX_BYTES (RX_BYTES),
    .MAX_BITS (MAX_BITS),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .busy      (busy),
    .strb      (strb),
    .miso      (spiMiso),
    .mosi      (spiMosi),
    .startReq  (startReq),
    .bitTotal  (bitTotal)
  );

endmodule

// File: tb/test_flash_byte_shifter.sv
module test_flash_byte_shifter;

  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busWrEn;
  logic [4:0] busAddr;
  logic [7:0] busWrData;
  logic [7:0] busRdData;
  logic       spiCsN, spiSclk, spiMosi;
  logic       spiMiso;

  always #10 clk = ~clk;

  flash_byte_shifter #(.HALF_DIV(HALF)) i_flash_byte_shifter (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .spiCsN(spiCsN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso));

  typedef struct {
    logic [55:0] mosiExp;
    int          bits;
  } xfer_t;

  xfer_t       expQ[$];
  int          checks = 0;
  int          fails  = 0;
  logic [7:0]  txModel [6];
  logic [7:0]  rxModel [10];
  logic [55:0] misoPat = '0;
  logic [55:0] slaveSh = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Flash model: presents the next response bit after each falling edge.
  initial spiMiso = 1'b0;
  always @(negedge spiCsN) begin
    slaveSh = misoPat;
    spiMiso = slaveSh[55];
  end
  always @(negedge spiSclk) begin
    if (spiCsN === 1'b0) begin
      slaveSh = {slaveSh[54:0], 1'b0};
      spiMiso = slaveSh[55];
    end
  end

  // Monitor: measures the wire and compares each transaction with the queue.
  int          cyc = 0, lastEdge = 0, pulses = 0, csFalls = 0;
  logic [55:0] cap = '0;
  bit          timingBad = 0;
  logic        prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN === 1'b1) begin
      if (prevCs && !spiCsN) begin
        csFalls++; lastEdge = cyc; pulses = 0; cap = '0; timingBad = 0;
      end
      if (!prevSclk && spiSclk) begin
        if (cyc - lastEdge != HALF) timingBad = 1;
        pulses++; cap = {cap[54:0], spiMosi}; lastEdge = cyc;
      end
      if (prevSclk && !spiSclk) begin
        if (cyc - lastEdge != HALF) timingBad = 1;
        lastEdge = cyc;
      end
      if (prevSclk && spiSclk && (spiMosi != prevMosi)) timingBad = 1;
      if (spiCsN && spiSclk) timingBad = 1;
      if (!prevCs && spiCsN) begin
        xfer_t       e;
        logic [55:0] mask, got;
        if (cyc - lastEdge != HALF) timingBad = 1;
        if (expQ.size() == 0) begin
          check(0, "R3", "unexpected transaction", pulses, 0);
        end else begin
          e    = expQ.pop_front();
          mask = ~56'd0 << (56 - e.bits);
          got  = cap << (56 - pulses);
          check(pulses == e.bits, "R11", "clock pulse count", pulses, e.bits);
          check((got & mask) == (e.mosiExp & mask), "R4 R5", "mosi bits",
                got & mask, e.mosiExp & mask);
          check(!timingBad, "R7", "mode 0 timing", timingBad, 0);
        end
      end
    end
    prevCs = spiCsN; prevSclk = spiSclk; prevMosi = spiMosi;
  end

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setTx(input int i, input logic [7:0] d);
    busWrite(5'(8 + i), d);
    txModel[i] = d;
  endtask

  task automatic startXfer(input int bits, input logic [55:0] mpat);
    xfer_t e;
    misoPat   = mpat;
    e.mosiExp = {txModel[5], txModel[4], txModel[3], txModel[2],
                 txModel[1], txModel[0], 8'h00};
    e.bits    = bits;
    expQ.push_back(e);
    for (int j = 0; j < bits / 8; j++) begin
      for (int k = 9; k > 0; k--) rxModel[k] = rxModel[k-1];
      rxModel[0] = mpat[55 - 8*j -: 8];
    end
    busWrite(5'd1, 8'(bits));
    busWrite(5'd0, 8'h04);
  endtask

  task automatic waitIdle();
    logic [7:0] d;
    for (int n = 0; n < 2000; n++) begin
      busRead(5'd0, d);
      if (!d[2]) break;
    end
    check(d[2] == 1'b0, "R3", "go bit self-clears", d[2], 0);
  endtask

  task automatic checkRx(input string req);
    logic [7:0] d;
    for (int k = 0; k < 10; k++) begin
      busRead(5'(16 + k), d);
      check(d == rxModel[k], req, $sformatf("rx[%0d]", k), d, rxModel[k]);
    end
  endtask

  task automatic runXfer(input int bits, input logic [55:0] mpat, input string req);
    startXfer(bits, mpat);
    waitIdle();
    checkRx(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int         f0;
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    for (int k = 0; k < 10; k++) rxModel[k] = '0;
    for (int k = 0; k < 6; k++) txModel[k] = '0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(spiCsN == 1'b1, "R1", "chip select idle", spiCsN, 1);
    check(spiSclk == 1'b0, "R1", "clock idle", spiSclk, 0);
    busRead(5'd0, d); check(d == 8'h00, "R1", "command reset", d, 0);
    busRead(5'd1, d); check(d == 8'h00, "R1", "count reset", d, 0);
    checkRx("R1");

    // R2: map and read back
    busRead(5'd5, d);  check(d == 8'h00, "R2", "unmapped addr 5", d, 0);
    busRead(5'd31, d); check(d == 8'h00, "R2", "unmapped addr 31", d, 0);
    setTx(0, 8'h11); setTx(1, 8'h22); setTx(2, 8'h33);
    setTx(3, 8'h44); setTx(4, 8'h55); setTx(5, 8'h9F);
    for (int i = 0; i < 6; i++) begin
      busRead(5'(8 + i), d);
      check(d == txModel[i], "R2", "tx readback", d, txModel[i]);
    end

    // R6: saturation of the bit count
    busWrite(5'd1, 8'd60);  busRead(5'd1, d); check(d == 8'd56, "R6", "count 60", d, 56);
    busWrite(5'd1, 8'd255); busRead(5'd1, d); check(d == 8'd56, "R6", "count 255", d, 56);
    busWrite(5'd1, 8'd56);  busRead(5'd1, d); check(d == 8'd56, "R6", "count 56", d, 56);

    // R3: non-start command bits are stored and do nothing
    f0 = csFalls;
    busWrite(5'd0, 8'h39);
    busRead(5'd0, d); check(d == 8'h39, "R3", "command bits", d, 8'h39);
    repeat (10) @(negedge clk);
    check(csFalls == f0, "R3", "no start without bit 2", csFalls, f0);

    // R4 R9: two-byte transaction
    runXfer(16, 56'hA5C3_0000_0000_00, "R9");
    busRead(5'd0, d); check(d == 8'h00, "R3", "command after start", d, 0);

    // R5: full length, zero fill after 48 bits
    runXfer(56, 56'h0102_0304_0506_07, "R9");

    // R9: partial trailing bits not stored
    setTx(5, 8'h6B); setTx(0, 8'hF0);
    runXfer(13, 56'hE7FF_FFFF_FFFF_FF, "R9");

    // R8: zero length
    f0 = csFalls;
    busWrite(5'd1, 8'd0);
    busWrite(5'd0, 8'h04);
    busRead(5'd0, d); check(d == 8'h00, "R8", "go bit after zero length", d, 0);
    repeat (10) @(negedge clk);
    check(csFalls == f0, "R8", "no chip select", csFalls, f0);
    checkRx("R8");

    // R10: writes during a transaction are ignored; oldest rx byte drops (R9)
    f0 = csFalls;
    startXfer(56, 56'hDEAD_BEEF_CAFE_12);
    repeat (6) @(negedge clk);
    busWrite(5'd11, 8'hEE);
    busWrite(5'd1, 8'd8);
    busWrite(5'd0, 8'h3C);
    waitIdle();
    repeat (20) @(negedge clk);
    busRead(5'd11, d); check(d == txModel[3], "R10", "tx while busy", d, txModel[3]);
    busRead(5'd1, d);  check(d == 8'd56, "R10", "count while busy", d, 56);
    busRead(5'd0, d);  check(d == 8'h00, "R10", "command while busy", d, 0);
    check(csFalls == f0 + 1, "R10", "single transaction", csFalls, f0 + 1);
    check(expQ.size() == 0, "R10", "queue drained", expQ.size(), 0);
    checkRx("R9");

    // R4: another pattern, three bytes
    setTx(5, 8'h80); setTx(4, 8'h01); setTx(3, 8'h7E);
    runXfer(24, 56'h5A_3C96_0000_0000, "R9");
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R11", "all transactions seen", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule